// File: doc/BRIEF.md
# Vectored Eight-Source Interrupt Controller

This block gathers eight single-cycle event pulses from on-chip hardware and records each in a sticky pending register. It drives one interrupt request line to the processor while at least one pending source is also enabled. Bit positions carry a fixed meaning: 7 horizontal timer, 6 vertical blank, 5 vertical timer, 4 line match, 3 serial receive, 2 alarm, 1 key press, 0 serial send.

Software sees a small register window with three registers: a vector base, an enable mask and a pending/clear register. Reading the pending register returns the latched events. Writing it clears every bit written as 1, and only such a write clears a bit. When the processor answers a request with its acknowledge pulse, the block latches a vector number onto its vector output. That number is the base plus the bit index of the highest-numbered enabled pending source.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, the base, enable and pending registers read as 0x00, irq_o is low and vector_o is 0x00.
- R2: An event pulse on evt_i[n] sets pending bit n from the next cycle on, and the bit stays set across later cycles without events.
- R3: A write to address 2 clears each pending bit whose write-data bit is 1 and leaves the other pending bits unchanged.
- R4: When evt_i[n] and a write to address 2 with data bit n set occur in the same cycle, pending bit n remains set.
- R5: irq_o is high exactly while some bit is set in both the pending register and the enable register (address 1).
- R6: A source whose enable bit is 0 is still latched as pending but does not raise irq_o; setting its enable bit later raises irq_o.
- R7: A cpu_ack_i pulse while irq_o is high loads vector_o, from the next cycle on, with base (address 0) plus the index of the highest-numbered enabled pending bit.
- R8: vector_o changes only on a cpu_ack_i pulse that finds an enabled pending bit; an acknowledge with none leaves it unchanged.
- R9: The vector sum wraps modulo 256 (base 0xFE with source 7 gives 0x05).
- R10: reg_rdata_o returns base at address 0, enable at address 1, pending at address 2 and 0x00 at address 3; writes to address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 base, 1 enable, 2 pending/clear, 3 unused |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from reg_addr_i |
| evt_i | input | 8 | Event pulses, one per source |
| irq_o | output | 1 | Interrupt request to the processor |
| cpu_ack_i | input | 1 | Processor interrupt acknowledge pulse |
| vector_o | output | 8 | Latched interrupt vector number |

## Verification
The hardest case to reach from the ports is an event that lands in the same cycle as a software clear of that same bit. The stimulus table drives that event and the clear write in one step, then reads the pending register back. A second hard case is an acknowledge while several enabled sources are pending. The table builds up two pending sources before it pulses cpu_ack_i, and it then clears the higher one to show the lower one take over. Wrap-around of the vector sum is reached by programming a base near the top of the range and raising source 7.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int ADDR_W = 2;
   localparam logic [ADDR_W-1:0] A_BASE = 2'd0;
   localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
   localparam logic [ADDR_W-1:0] A_PEND = 2'd2;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int NSRC = 8,
   parameter int DW   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic [NSRC-1:0]   pend_i,
   output logic [DW-1:0]     rdata_o,
   output logic [DW-1:0]     base_o,
   output logic [NSRC-1:0]   mask_o,
   output logic [NSRC-1:0]   clr_o
);
   logic [DW-1:0]   base_q;
   logic [NSRC-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
      end else if (wr_i) begin
         if (addr_i == A_BASE) base_q <= wdata_i;
         if (addr_i == A_MASK) mask_q <= wdata_i[NSRC-1:0];
      end
   end

   always_comb begin
      clr_o = '0;
      if (wr_i && addr_i == A_PEND) clr_o = wdata_i[NSRC-1:0];
   end

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         A_BASE:  rdata_o = base_q;
         A_MASK:  rdata_o[NSRC-1:0] = mask_q;
         A_PEND:  rdata_o[NSRC-1:0] = pend_i;
         default: rdata_o = '0;
      endcase
   end

   assign base_o = base_q;
   assign mask_o = mask_q;
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
   parameter int NSRC = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] evt_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] pend_o
);
   for (genvar g = 0; g < NSRC; g++) begin : g_bit
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        hit_q <= 1'b0;
         else if (evt_i[g]) hit_q <= 1'b1;
         else if (clr_i[g]) hit_q <= 1'b0;
      end
      assign pend_o[g] = hit_q;

      // R2, R4: an event always lands, even against a clear
      p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
         evt_i[g] |=> pend_o[g]);
      p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_o[g] && !clr_i[g]) |=> pend_o[g]);
      p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[g] && !evt_i[g]) |=> !pend_o[g]);
   end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int NSRC      = 8,
   parameter bit HIGH_WINS = 1'b1,
   localparam int IW       = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic [NSRC-1:0] req_i,
   output logic            found_o,
   output logic [IW-1:0]   idx_o
);
   assign found_o = |req_i;

   if (HIGH_WINS) begin : g_high
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < NSRC; i++)
            if (req_i[i]) idx_o = IW'(i);
      end
   end else begin : g_low
      always_comb begin
         idx_o = '0;
         for (int i = NSRC - 1; i >= 0; i--)
            if (req_i[i]) idx_o = IW'(i);
      end
   end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int NSRC      = 8,
   parameter int DW        = 8,
   parameter bit HIGH_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DW-1:0]     reg_wdata_i,
   output logic [DW-1:0]     reg_rdata_o,
   input  logic [NSRC-1:0]   evt_i,
   output logic              irq_o,
   input  logic              cpu_ack_i,
   output logic [DW-1:0]     vector_o
);
   localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

   if (DW < NSRC) begin : g_chk_dw
      $error("DW must hold one bit per source");
   end
   if (NSRC < 1) begin : g_chk_n
      $error("NSRC must be at least 1");
   end

   logic [DW-1:0]   base;
   logic [NSRC-1:0] mask, clr, pend, live;
   logic            found;
   logic [IW-1:0]   idx;
   logic [DW-1:0]   vec_q;

   irqc_regs #(.NSRC(NSRC), .DW(DW)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
      .wdata_i(reg_wdata_i), .pend_i(pend), .rdata_o(reg_rdata_o),
      .base_o(base), .mask_o(mask), .clr_o(clr));

   irqc_pend #(.NSRC(NSRC)) pend_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr), .pend_o(pend));

   assign live = pend & mask;

   irqc_prio #(.NSRC(NSRC), .HIGH_WINS(HIGH_WINS)) prio_i (
      .req_i(live), .found_o(found), .idx_o(idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  vec_q <= '0;
      else if (cpu_ack_i && found) vec_q <= base + DW'(idx);
   end

   assign irq_o    = found;
   assign vector_o = vec_q;

   // R5: a request only appears after an event or a register write
   p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past((|evt_i) || reg_wr_i));
   // R8: vector only moves on an acknowledge
   p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_ack_i |=> $stable(vector_o));
   // R8: acknowledge without request keeps the vector
   p_vec_noreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack_i && !irq_o) |=> $stable(vector_o));
endmodule

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr_i = 1'b0;
   logic [1:0] reg_addr_i = 2'd0;
   logic [7:0] reg_wdata_i = 8'h00;
   logic [7:0] reg_rdata_o;
   logic [7:0] evt_i = 8'h00;
   logic       irq_o;
   logic       cpu_ack_i = 1'b0;
   logic [7:0] vector_o;

   int n_run = 0;
   int n_bad = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   evt_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .evt_i(evt_i),
      .irq_o(irq_o), .cpu_ack_i(cpu_ack_i), .vector_o(vector_o));

   // fields: req(4) wr(1) addr(2) wdata(8) evt(8) ack(1) exp_irq(1) exp_vec(8) exp_pend(8)
   localparam int TW = 41;
   localparam int NT = 14;
   localparam logic [TW-1:0] TBL [NT] = '{
      {4'd10,1'b1,2'd0,8'h20,8'h00,1'b0,1'b0,8'h00,8'h00}, // R10 base write
      {4'd6, 1'b0,2'd0,8'h00,8'h40,1'b0,1'b0,8'h00,8'h40}, // R6 latched, masked
      {4'd6, 1'b1,2'd1,8'h42,8'h00,1'b0,1'b1,8'h00,8'h40}, // R6 enable raises irq
      {4'd7, 1'b0,2'd0,8'h00,8'h00,1'b1,1'b1,8'h26,8'h40}, // R7 0x20+6
      {4'd2, 1'b0,2'd0,8'h00,8'h02,1'b0,1'b1,8'h26,8'h42}, // R2 sticky plus new
      {4'd7, 1'b0,2'd0,8'h00,8'h00,1'b1,1'b1,8'h26,8'h42}, // R7 highest wins
      {4'd3, 1'b1,2'd2,8'h40,8'h00,1'b0,1'b1,8'h26,8'h02}, // R3 selective clear
      {4'd7, 1'b0,2'd0,8'h00,8'h00,1'b1,1'b1,8'h21,8'h02}, // R7 lower source
      {4'd4, 1'b1,2'd2,8'h02,8'h02,1'b0,1'b1,8'h21,8'h02}, // R4 event beats clear
      {4'd5, 1'b1,2'd2,8'hFF,8'h00,1'b0,1'b0,8'h21,8'h00}, // R5 irq drops
      {4'd8, 1'b0,2'd0,8'h00,8'h00,1'b1,1'b0,8'h21,8'h00}, // R8 empty ack
      {4'd5, 1'b1,2'd0,8'hFE,8'h80,1'b0,1'b0,8'h21,8'h80}, // R5 bit7 not enabled
      {4'd9, 1'b1,2'd1,8'hFF,8'h00,1'b1,1'b1,8'h21,8'h80}, // R9 ack sees old mask
      {4'd9, 1'b0,2'd0,8'h00,8'h00,1'b1,1'b1,8'h05,8'h80}  // R9 0xFE+7 wraps
   };

   task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr_i = a;
      #1 d = reg_rdata_o;
   endtask

   initial begin : watchdog
      while (cyc < 5000) @(posedge clk) cyc++;
      n_bad++;
      $display("FAIL R0 watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      logic [TW-1:0] e;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(2'd0, d); chk(1, "base", d, 8'h00);
      rd(2'd1, d); chk(1, "enable", d, 8'h00);
      rd(2'd2, d); chk(1, "pending", d, 8'h00);
      chk(1, "irq", {7'd0, irq_o}, 8'h00);
      chk(1, "vector", vector_o, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NT; i++) begin
         e = TBL[i];
         reg_wr_i    = e[36];
         reg_addr_i  = e[35:34];
         reg_wdata_i = e[33:26];
         evt_i       = e[25:18];
         cpu_ack_i   = e[17];
         @(posedge clk);
         #1;
         reg_wr_i = 1'b0; evt_i = 8'h00; cpu_ack_i = 1'b0;
         rd(2'd2, d);
         chk(int'(e[40:37]), $sformatf("step %0d pending", i), d, e[7:0]);
         chk(int'(e[40:37]), $sformatf("step %0d irq", i), {7'd0, irq_o}, {7'd0, e[16]});
         chk(int'(e[40:37]), $sformatf("step %0d vector", i), vector_o, e[15:8]);
         @(negedge clk);
      end
      // R10 readback and unused address
      @(negedge clk);
      reg_wr_i = 1'b1; reg_addr_i = 2'd3; reg_wdata_i = 8'h55;
      @(negedge clk);
      reg_wr_i = 1'b0;
      rd(2'd0, d); chk(10, "base after addr3 write", d, 8'hFE);
      rd(2'd1, d); chk(10, "enable after addr3 write", d, 8'hFF);
      rd(2'd2, d); chk(10, "pending after addr3 write", d, 8'h80);
      rd(2'd3, d); chk(10, "addr3 reads", d, 8'h00);
      // R1 reset mid-run
      rst_n = 1'b0;
      #2;
      rd(2'd2, d); chk(1, "pending in reset", d, 8'h00);
      rd(2'd0, d); chk(1, "base in reset", d, 8'h00);
      chk(1, "vector in reset", vector_o, 8'h00);
      chk(1, "irq in reset", {7'd0, irq_o}, 8'h00);
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule